// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block works out the outcome of one branch instruction for each valid strobe. It takes a 32-bit instruction word together with the current program counter, the count register, the link register and the 32-bit condition register. From these it computes the next program counter, the updated count and link registers, and a taken flag. It handles three kinds of branch. The first is the unconditional branch with a 24-bit word displacement. The second is the conditional branch with a 14-bit word displacement. The third is the conditional branch whose target comes from the link or the count register.

For the conditional kinds, a 5-bit option field picks the test. The count register can be decremented and compared with zero. A selected condition-register bit can be compared with an expected polarity. Either test, both or neither may apply. A mode input selects 32-bit addressing, which cuts every produced address down to its low 32 bits. All results are registered. They commit together on the clock edge that samples the strobe, and a one-cycle done pulse goes with them.

Top module: `branch_resolve`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is zero and `out_done` is low.
- R2: `out_done` is high for exactly the cycle after each cycle in which `in_valid` is high. While `in_valid` is low, the inputs have no effect and every result output holds its value.
- R3: For the conditional forms, the options field is instruction bits 25:21. When options bit 2 is 0, the count output equals the count input minus one, whether or not the branch is taken. The branch then fails when options bit 1 XOR (decremented count equals zero) is 1. When options bit 2 is 1, the count passes through unchanged.
- R4: For the conditional forms, when options bit 4 is 0, the branch fails unless condition-register bit (31 − index) equals options bit 3. The index is instruction bits 20:16.
- R5: The conditional-displacement form has primary opcode 16 in bits 31:26. Its target is {bits 15:2, 2'b00} sign-extended from bit 15. The current PC is added when bit 1 is 0, and nothing is added when bit 1 is 1.
- R6: The unconditional form has primary opcode 16 + 2 = 18. Its target is {bits 25:2, 2'b00} sign-extended from bit 25, plus the PC unless bit 1 is set. It is always taken and leaves the count unchanged.
- R7: When instruction bit 0 is 1 on a branch, the link output becomes PC+4. Otherwise the link register is unchanged.
- R8: The register-target form has primary opcode 19, with bits 10:1 equal to 16 or 528. Bit 10 selects the count register (1) or the link register (0) as the target. The value used is the one in place before any link update.
- R9: With `mode32` high, the fall-through address, the target and the saved link value are truncated to their low 32 bits.
- R10: A conditional branch that is not taken sets the next PC to PC+4.
- R11: Any other instruction word gives `out_is_branch` = 0 and `out_taken` = 0. The next PC equals the presented PC, and the count and link registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid strobe |
| instr | input | 32 | Instruction word |
| pc | input | AW | Current program counter |
| ctr_in | input | AW | Count register |
| lnk_in | input | AW | Link register |
| cr_in | input | 32 | Condition register |
| mode32 | input | 1 | 32-bit address mode |
| out_done | output | 1 | Result commit pulse |
| out_is_branch | output | 1 | Instruction was a recognised branch |
| out_taken | output | 1 | Branch taken |
| next_pc | output | AW | Next program counter |
| ctr_out | output | AW | Updated count register |
| lnk_out | output | AW | Updated link register |

## Verification
Every result output, including `out_done`, is due on the first rising edge after the cycle in which `in_valid` is high. Nothing is due later. The bench changes inputs on falling edges and reads each result on the falling edge that follows that rising edge. On the falling edge after that, it confirms that the done pulse has dropped and that the results have held. Idle cycles with scrambled operands then show that nothing moves without the strobe.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam logic [5:0] OPC_COND_DISP = 6'd16;
    localparam logic [5:0] OPC_UNCOND    = 6'd18;
    localparam logic [5:0] OPC_COND_REG  = 6'd19;
    localparam logic [9:0] XO_TO_LINK    = 10'd16;
    localparam logic [9:0] XO_TO_COUNT   = 10'd528;

    typedef enum logic [1:0] {
        FORM_NONE      = 2'd0,
        FORM_UNCOND    = 2'd1,
        FORM_COND_DISP = 2'd2,
        FORM_COND_REG  = 2'd3
    } form_e;

    // decoded fields of one branch word
    typedef struct packed {
        form_e       form;
        logic        skip_cr;    // options bit 4
        logic        want_set;   // options bit 3
        logic        skip_ctr;   // options bit 2
        logic        want_zero;  // options bit 1
        logic [4:0]  bit_idx;
        logic        absolute;
        logic        link;
        logic        use_ctr;
        logic [15:0] disp16;
        logic [25:0] disp26;
    } branch_dec_t;

    function automatic logic is_conditional(input form_e f);
        return (f == FORM_COND_DISP) || (f == FORM_COND_REG);
    endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [31:0]  instr,
    output branch_dec_t  dec
);
    logic [5:0] opc;
    logic [9:0] xo;

    assign opc = instr[31:26];
    assign xo  = instr[10:1];

    always_comb begin
        dec.form = FORM_NONE;
        unique case (opc)
            OPC_COND_DISP: dec.form = FORM_COND_DISP;
            OPC_UNCOND:    dec.form = FORM_UNCOND;
            OPC_COND_REG:  if (xo == XO_TO_LINK || xo == XO_TO_COUNT)
                               dec.form = FORM_COND_REG;
            default:       dec.form = FORM_NONE;
        endcase
        dec.skip_cr   = instr[25];
        dec.want_set  = instr[24];
        dec.skip_ctr  = instr[23];
        dec.want_zero = instr[22];
        dec.bit_idx   = instr[20:16];
        dec.absolute  = instr[1];
        dec.link      = instr[0];
        dec.use_ctr   = instr[10];
        dec.disp16    = {instr[15:2], 2'b00};
        dec.disp26    = {instr[25:2], 2'b00};
    end
endmodule

// File: rtl/bru_condition.sv
module bru_condition
    import bru_pkg::*;
#(
    parameter int AW = 64
) (
    input  form_e          form,
    input  logic           skip_cr,
    input  logic           want_set,
    input  logic           skip_ctr,
    input  logic           want_zero,
    input  logic [4:0]     bit_idx,
    input  logic [AW-1:0]  ctr_in,
    input  logic [31:0]    cr_in,
    output logic [AW-1:0]  ctr_next,
    output logic           take
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic dec_en;
    logic zero_after;
    logic ctr_ok;
    logic cr_bit;
    logic cr_ok;

    assign dec_en     = is_conditional(form) && !skip_ctr;
    // count reaches zero after the decrement exactly when it is one now
    assign zero_after = (ctr_in == ONE);
    assign ctr_next   = dec_en ? (ctr_in - ONE) : ctr_in;
    assign ctr_ok     = !dec_en || ((want_zero ^ zero_after) == 1'b0);
    assign cr_bit     = cr_in[5'd31 - bit_idx];
    assign cr_ok      = skip_cr || (cr_bit == want_set);

    always_comb begin
        unique case (form)
            FORM_UNCOND:                  take = 1'b1;
            FORM_COND_DISP, FORM_COND_REG: take = ctr_ok && cr_ok;
            default:                      take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int AW = 64
) (
    input  form_e          form,
    input  logic           absolute,
    input  logic           use_ctr,
    input  logic [15:0]    disp16,
    input  logic [25:0]    disp26,
    input  logic [AW-1:0]  pc,
    input  logic [AW-1:0]  ctr_in,
    input  logic [AW-1:0]  lnk_in,
    input  logic           mode32,
    output logic [AW-1:0]  target,
    output logic [AW-1:0]  fall
);
    localparam int EXT16 = AW - 16;
    localparam int EXT26 = AW - 26;

    logic [AW-1:0] base;
    logic [AW-1:0] tgt_raw;
    logic [AW-1:0] fall_raw;

    assign base     = absolute ? '0 : pc;
    assign fall_raw = pc + AW'(4);

    always_comb begin
        unique case (form)
            FORM_UNCOND:    tgt_raw = {{EXT26{disp26[25]}}, disp26} + base;
            FORM_COND_DISP: tgt_raw = {{EXT16{disp16[15]}}, disp16} + base;
            FORM_COND_REG:  tgt_raw = use_ctr ? ctr_in : lnk_in;
            default:        tgt_raw = pc;
        endcase
    end

    generate
        if (AW > 32) begin : g_trunc
            localparam logic [AW-1:0] LOW_MASK = AW'(33'h0_FFFF_FFFF);
            assign target = mode32 ? (tgt_raw & LOW_MASK) : tgt_raw;
            assign fall   = mode32 ? (fall_raw & LOW_MASK) : fall_raw;
        end else begin : g_narrow
            logic unused_mode;
            assign unused_mode = mode32;
            assign target = tgt_raw;
            assign fall   = fall_raw;
        end
    endgenerate
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import bru_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [31:0]    instr,
    input  logic [AW-1:0]  pc,
    input  logic [AW-1:0]  ctr_in,
    input  logic [AW-1:0]  lnk_in,
    input  logic [31:0]    cr_in,
    input  logic           mode32,
    output logic           out_done,
    output logic           out_is_branch,
    output logic           out_taken,
    output logic [AW-1:0]  next_pc,
    output logic [AW-1:0]  ctr_out,
    output logic [AW-1:0]  lnk_out
);
    localparam logic [AW-1:0] LOW_MASK = AW'(33'h0_FFFF_FFFF);

    branch_dec_t   dec;
    logic [AW-1:0] ctr_next;
    logic          take;
    logic [AW-1:0] target;
    logic [AW-1:0] fall;
    logic          is_br;

    bru_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    bru_condition #(.AW(AW)) u_condition (
        .form      (dec.form),
        .skip_cr   (dec.skip_cr),
        .want_set  (dec.want_set),
        .skip_ctr  (dec.skip_ctr),
        .want_zero (dec.want_zero),
        .bit_idx   (dec.bit_idx),
        .ctr_in    (ctr_in),
        .cr_in     (cr_in),
        .ctr_next  (ctr_next),
        .take      (take)
    );

    bru_target #(.AW(AW)) u_target (
        .form     (dec.form),
        .absolute (dec.absolute),
        .use_ctr  (dec.use_ctr),
        .disp16   (dec.disp16),
        .disp26   (dec.disp26),
        .pc       (pc),
        .ctr_in   (ctr_in),
        .lnk_in   (lnk_in),
        .mode32   (mode32),
        .target   (target),
        .fall     (fall)
    );

    assign is_br = (dec.form != FORM_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_done      <= 1'b0;
            out_is_branch <= 1'b0;
            out_taken     <= 1'b0;
            next_pc       <= '0;
            ctr_out       <= '0;
            lnk_out       <= '0;
        end else begin
            out_done <= in_valid;
            if (in_valid) begin
                out_is_branch <= is_br;
                out_taken     <= take;
                next_pc       <= !is_br ? pc : (take ? target : fall);
                ctr_out       <= ctr_next;
                lnk_out       <= (is_br && dec.link) ? fall : lnk_in;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_done_follows_valid_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);

    assert_done_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(in_valid));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(next_pc) && $stable(ctr_out) && $stable(lnk_out)
                       && $stable(out_taken)));

    assert_count_decrements_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_conditional(dec.form) && !instr[23])
            |=> ctr_out == $past(ctr_in) - AW'(1));

    assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.form == FORM_UNCOND)
            |=> (out_taken && ctr_out == $past(ctr_in)));

    assert_link_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr[0]) |=> lnk_out == $past(lnk_in));

    assert_addr_trunc_R9: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_is_branch && $past(mode32))
            |-> (next_pc & ~LOW_MASK) == '0);

    assert_fallthrough_R10: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_is_branch && !out_taken && !$past(mode32))
            |-> next_pc == $past(pc) + AW'(4));

    assert_non_branch_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_br) |=> (!out_taken && next_pc == $past(pc)));
endmodule

// File: tb/test_branch_resolve.sv
module test_branch_resolve;
    localparam int AW = 64;

    typedef struct packed {
        logic [63:0] tag;
        logic [31:0] instr;
        logic [63:0] pc;
        logic [63:0] ctr;
        logic [63:0] lnk;
        logic [31:0] cr;
        logic        m32;
        logic [63:0] epc;
        logic [63:0] ectr;
        logic [63:0] elnk;
        logic        etk;
        logic        ebr;
    } vec_t;

    localparam int VW = $bits(vec_t);
    localparam int NV = 25;

    // tag, instr, pc, ctr, lnk, cr, mode32, exp pc, exp ctr, exp lnk, exp taken, exp branch
    localparam logic [VW-1:0] VECS [NV] = '{
        {"R5 rel  ", 32'h42800100, 64'h1000, 64'h5, 64'h77, 32'h0, 1'b0, 64'h1100, 64'h5, 64'h77, 1'b1, 1'b1},
        {"R4 R7   ", 32'h4182FFF9, 64'h2000, 64'h5, 64'h77, 32'h20000000, 1'b0, 64'h1FF8, 64'h5, 64'h2004, 1'b1, 1'b1},
        {"R4 R10  ", 32'h4182FFF9, 64'h2000, 64'h5, 64'h77, 32'h0, 1'b0, 64'h2004, 64'h5, 64'h2004, 1'b0, 1'b1},
        {"R3 nz   ", 32'h42000040, 64'h3000, 64'h3, 64'h77, 32'h0, 1'b0, 64'h3040, 64'h2, 64'h77, 1'b1, 1'b1},
        {"R3 R10  ", 32'h42000040, 64'h3000, 64'h1, 64'h77, 32'h0, 1'b0, 64'h3004, 64'h0, 64'h77, 1'b0, 1'b1},
        {"R3 wrap ", 32'h42000040, 64'h3000, 64'h0, 64'h77, 32'h0, 1'b0, 64'h3040, 64'hFFFFFFFFFFFFFFFF, 64'h77, 1'b1, 1'b1},
        {"R3 z    ", 32'h42400040, 64'h3000, 64'h1, 64'h77, 32'h0, 1'b0, 64'h3040, 64'h0, 64'h77, 1'b1, 1'b1},
        {"R5 abs  ", 32'h42800802, 64'h5000, 64'h5, 64'h77, 32'h0, 1'b0, 64'h800, 64'h5, 64'h77, 1'b1, 1'b1},
        {"R5 absn ", 32'h42808002, 64'h5000, 64'h5, 64'h77, 32'h0, 1'b0, 64'hFFFFFFFFFFFF8000, 64'h5, 64'h77, 1'b1, 1'b1},
        {"R9 absn ", 32'h42808002, 64'h5000, 64'h5, 64'h77, 32'h0, 1'b1, 64'hFFFF8000, 64'h5, 64'h77, 1'b1, 1'b1},
        {"R6 R7   ", 32'h48000101, 64'h10000, 64'h5, 64'h77, 32'h0, 1'b0, 64'h10100, 64'h5, 64'h10004, 1'b1, 1'b1},
        {"R6 neg  ", 32'h4BFFFFFC, 64'h10000, 64'h5, 64'h77, 32'h0, 1'b0, 64'hFFFC, 64'h5, 64'h77, 1'b1, 1'b1},
        {"R6 abs  ", 32'h49FFFFFE, 64'h10000, 64'h5, 64'h77, 32'h0, 1'b0, 64'h1FFFFFC, 64'h5, 64'h77, 1'b1, 1'b1},
        {"R9 wrap ", 32'h48000009, 64'hFFFFFFFC, 64'h5, 64'h77, 32'h0, 1'b1, 64'h4, 64'h5, 64'h0, 1'b1, 1'b1},
        {"R6 wide ", 32'h48000009, 64'hFFFFFFFC, 64'h5, 64'h77, 32'h0, 1'b0, 64'h100000004, 64'h5, 64'h100000000, 1'b1, 1'b1},
        {"R8 lnk  ", 32'h4E800020, 64'h9000, 64'h5, 64'h8000, 32'h0, 1'b0, 64'h8000, 64'h5, 64'h8000, 1'b1, 1'b1},
        {"R8 lnkLK", 32'h4E800021, 64'h9000, 64'h5, 64'h8000, 32'h0, 1'b0, 64'h8000, 64'h5, 64'h9004, 1'b1, 1'b1},
        {"R8 ctr  ", 32'h4E800420, 64'h9000, 64'hA000, 64'h8000, 32'h0, 1'b0, 64'hA000, 64'hA000, 64'h8000, 1'b1, 1'b1},
        {"R3 R8   ", 32'h4E000020, 64'h9000, 64'h1, 64'h8000, 32'h0, 1'b0, 64'h9004, 64'h0, 64'h8000, 1'b0, 1'b1},
        {"R9 R8   ", 32'h4E800020, 64'h9000, 64'h5, 64'hFFFFFFFF00008000, 32'h0, 1'b1, 64'h8000, 64'h5, 64'hFFFFFFFF00008000, 1'b1, 1'b1},
        {"R4 both ", 32'h401F0010, 64'h100, 64'h2, 64'h77, 32'hFFFFFFFE, 1'b0, 64'h110, 64'h1, 64'h77, 1'b1, 1'b1},
        {"R4 R3   ", 32'h401F0010, 64'h100, 64'h2, 64'h77, 32'hFFFFFFFF, 1'b0, 64'h104, 64'h1, 64'h77, 1'b0, 1'b1},
        {"R11 add ", 32'h38000000, 64'h100, 64'h5, 64'h77, 32'h0, 1'b0, 64'h100, 64'h5, 64'h77, 1'b0, 1'b0},
        {"R11 x19 ", 32'h4C00012D, 64'h100, 64'h5, 64'h77, 32'h0, 1'b0, 64'h100, 64'h5, 64'h77, 1'b0, 1'b0},
        {"R9 hipc ", 32'h42800100, 64'h1234567800001000, 64'h5, 64'h77, 32'h0, 1'b1, 64'h1100, 64'h5, 64'h77, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [31:0]   instr;
    logic [AW-1:0] pc, ctr_in, lnk_in;
    logic [31:0]   cr_in;
    logic          mode32;
    logic          out_done, out_is_branch, out_taken;
    logic [AW-1:0] next_pc, ctr_out, lnk_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    branch_resolve #(.AW(AW)) i_branch_resolve (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .instr         (instr),
        .pc            (pc),
        .ctr_in        (ctr_in),
        .lnk_in        (lnk_in),
        .cr_in         (cr_in),
        .mode32        (mode32),
        .out_done      (out_done),
        .out_is_branch (out_is_branch),
        .out_taken     (out_taken),
        .next_pc       (next_pc),
        .ctr_out       (ctr_out),
        .lnk_out       (lnk_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        instr    = v.instr;
        pc       = v.pc;
        ctr_in   = v.ctr;
        lnk_in   = v.lnk;
        cr_in    = v.cr;
        mode32   = v.m32;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_vec(input vec_t v);
        string t;
        t = $sformatf("%s", v.tag);
        chk(out_done == 1'b1, t, "done", 64'(out_done), 64'd1);
        chk(next_pc == v.epc, t, "next_pc", next_pc, v.epc);
        chk(ctr_out == v.ectr, t, "ctr_out", ctr_out, v.ectr);
        chk(lnk_out == v.elnk, t, "lnk_out", lnk_out, v.elnk);
        chk(out_taken == v.etk, t, "taken", 64'(out_taken), 64'(v.etk));
        chk(out_is_branch == v.ebr, t, "is_branch", 64'(out_is_branch), 64'(v.ebr));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        vec_t v;
        rst = 1'b1; in_valid = 1'b0; instr = '0; pc = '0; ctr_in = '0;
        lnk_in = '0; cr_in = '0; mode32 = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(out_done == 0 && out_taken == 0 && out_is_branch == 0, "R1", "flags in reset",
            {61'd0, out_done, out_taken, out_is_branch}, 64'd0);
        chk(next_pc == 0 && ctr_out == 0 && lnk_out == 0, "R1", "regs in reset",
            next_pc | ctr_out | lnk_out, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_done == 0 && next_pc == 0, "R1", "after reset", next_pc, 64'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = vec_t'(VECS[i]);
            apply(v);
            check_vec(v);
            @(negedge clk);
            // R2: pulse lasts one cycle, results held
            chk(out_done == 1'b0, "R2", "done pulse width", 64'(out_done), 64'd0);
            chk(next_pc == v.epc, "R2", "hold next_pc", next_pc, v.epc);
        end

        // R2: idle cycles with changing operands have no effect
        v = vec_t'(VECS[0]);
        apply(v);
        for (int k = 0; k < 4; k++) begin
            instr = 32'h48000001 + 32'(k * 4); pc = 64'hDEAD0000 + 64'(k);
            ctr_in = 64'h1; lnk_in = 64'hBEEF; cr_in = 32'hFFFFFFFF; mode32 = k[0];
            @(negedge clk);
            chk(out_done == 1'b0 && next_pc == 64'h1100 && ctr_out == 64'h5 && lnk_out == 64'h77,
                "R2", "idle inputs ignored", next_pc, 64'h1100);
        end

        // R2: back-to-back strobes each commit
        v = vec_t'(VECS[3]);
        instr = v.instr; pc = v.pc; ctr_in = v.ctr; lnk_in = v.lnk; cr_in = v.cr;
        mode32 = v.m32; in_valid = 1'b1;
        @(negedge clk);
        check_vec(v);
        v = vec_t'(VECS[10]);
        instr = v.instr; pc = v.pc; ctr_in = v.ctr; lnk_in = v.lnk; cr_in = v.cr;
        mode32 = v.m32;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(v);

        // R1: reset mid-run clears results
        rst = 1'b1;
        @(negedge clk);
        chk(next_pc == 0 && lnk_out == 0 && out_taken == 0, "R1", "reset clears",
            next_pc | lnk_out, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule